// File: doc/BRIEF.md
# Shared Interrupt Source Conditioner

This block takes a bank of external interrupt wires shared by several cores and turns each one into a clean pending flag. Each source has its own sense setting: active high or active low, level or edge, and an option to catch both edges. It also has an enable mask and a route to one core and one output pin of that core. Software reaches every setting through a small 32-bit register port with write strobe, word-aligned byte address and combinational read data. A single "wedge" register lets software raise or drop any source by index. The same write is used to acknowledge a latched edge.

Each core gets one interrupt line. The line is the OR of all sources that are pending, enabled and routed to that core. Each core also gets a vector of pin lines, and a pin line further requires a valid pin mapping that selects that pin. The pending and mask state can be read back as packed 32-bit words.

Register map (byte addresses; word k covers sources 32k..32k+31, bit j is source 32k+j):

| Address | Name | Access |
|---|---|---|
| 0x000 | config | read only |
| 0x004 | wedge | write only |
| 0x100 + 4k | polarity | read/write |
| 0x180 + 4k | trigger | read/write |
| 0x200 + 4k | both-edge | read/write |
| 0x280 + 4k | pending | read only |
| 0x300 + 4k | mask | read only |
| 0x380 + 4k | mask set | write only |
| 0x400 + 4k | mask clear | write only |
| 0x800 + 4i | pin map of source i | read/write |
| 0xC00 + 4i | core map of source i | read/write |

Writes whose address has bits [1:0] not zero are ignored.

Top module: `shared_irq_cond`

## Requirements
- R1: After reset, every source is masked, active high and level sensed, with both-edge off. Pending and mask words read 0, each core map reads 1 (core 0), each pin map reads 0 (invalid), and all core lines are low.
- R2: A 1 written to bit j of mask-set word k (0x380+4k) enables source 32k+j, and a 1 in mask-clear word k (0x400+4k) disables it. Bits written as 0 leave their sources unchanged.
- R3: A level source is pending while its synchronized input XOR its polarity bit is 1, or while its software assertion is held. It is not latched, and an input change reaches pending after two clock edges. Polarity bit 1 means active low.
- R4: An edge source with both-edge off latches pending on a rising input edge when its polarity bit is 0, and on a falling input edge when it is 1. The latch holds after the input returns, until it is acknowledged. Transitions of the opposite direction do not set it.
- R5: An edge source with both-edge set latches pending on either transition, and its polarity bit has no effect.
- R6: A wedge write (0x004) carries the command in bit 31 (1 = set, 0 = clear) and the source index in bits [7:0]. A set makes a level source pending and sets an edge source's latch. A clear drops the software assertion and acknowledges an edge latch. An index of NUM_SRC or more changes nothing.
- R7: Writing the core map of a source routes it to the core of the lowest set bit in bits [NUM_CORE-1:0] of the written data, and the old route is removed in the same write. The map reads back as that one-hot value. core_irq[c] is high exactly when some pending, enabled source is routed to core c.
- R8: A pin map holds a valid flag in bit 31 and a pin number in bits [PIN_W-1:0]. core_pin_irq[c*2^PIN_W+p] is high exactly when some pending, enabled source routed to core c has a valid map to pin p.
- R9: The pending word shows sources whether masked or not. Consecutive words of pending, mask and sense settings sit 4 bytes apart.
- R10: The config register reads NUM_SRC/8-1 in bits [23:16] and NUM_CORE-1 in bits [7:0], with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw external interrupt inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_irq | output | NUM_CORE | Interrupt line per core |
| core_pin_irq | output | NUM_CORE*2^PIN_W | Pin lines, core c at bits c*2^PIN_W upward |

## Verification
The hardest case to reach from the ports is an edge latch that must survive an opposite transition. The rising edge that arms an active-low falling-edge source, and the return to zero after a rising pulse, must both leave the latch alone. The stimulus gets there by first reconfiguring a source through its level phase into edge mode. It then drives one-cycle and long pulses through the synchronizer and acknowledges with clear-type wedge writes between the edges. A reference model tracks the two-flop delay, so the core and pin lines are compared on every clock, including the cycles just after a route or pin map changes.

// File: rtl/shint_pkg.sv
package shint_pkg;
   localparam logic [11:0] A_CFG   = 12'h000;
   localparam logic [11:0] A_WEDGE = 12'h004;
   localparam logic [4:0]  WIN_POL   = 5'd2;
   localparam logic [4:0]  WIN_TRIG  = 5'd3;
   localparam logic [4:0]  WIN_DUAL  = 5'd4;
   localparam logic [4:0]  WIN_PEND  = 5'd5;
   localparam logic [4:0]  WIN_MASK  = 5'd6;
   localparam logic [4:0]  WIN_SMASK = 5'd7;
   localparam logic [4:0]  WIN_RMASK = 5'd8;
   localparam logic [1:0]  REG_PIN  = 2'd2;
   localparam logic [1:0]  REG_CORE = 2'd3;
   localparam int CMD_BIT   = 31;
   localparam int VALID_BIT = 31;

   typedef struct packed {
      logic neg;
      logic edge_mode;
      logic both;
   } sense_t;
endpackage

// File: rtl/shint_src_cell.sv
module shint_src_cell
   import shint_pkg::*;
#(
   parameter bit SYNC_EN = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   src_in,
   input  sense_t sense,
   input  logic   wset,
   input  logic   wclr,
   input  logic   mask_set,
   input  logic   mask_clr,
   output logic   pend,
   output logic   mask
);
   logic s_now, prev_q, sw_q, latch_q, mask_q, edge_hit;

   generate
      if (SYNC_EN) begin : g_sync
         logic [1:0] sy;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy <= '0;
            else        sy <= {sy[0], src_in};
         end
         assign s_now = sy[1];
      end else begin : g_raw
         assign s_now = src_in;
      end
   endgenerate

   always_comb begin
      if (sense.both)     edge_hit = s_now ^ prev_q;
      else if (sense.neg) edge_hit = prev_q & ~s_now;
      else                edge_hit = ~prev_q & s_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         sw_q    <= 1'b0;
         latch_q <= 1'b0;
         mask_q  <= 1'b0;
      end else begin
         prev_q <= s_now;
         if (!sense.edge_mode) latch_q <= 1'b0;
         else                  latch_q <= (latch_q & ~wclr) | edge_hit | wset;
         if (wset)      sw_q <= 1'b1;
         else if (wclr) sw_q <= 1'b0;
         if (mask_set)      mask_q <= 1'b1;
         else if (mask_clr) mask_q <= 1'b0;
      end
   end

   assign pend = sense.edge_mode ? latch_q : ((s_now ^ sense.neg) | sw_q);
   assign mask = mask_q;

   p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mask_set |=> mask);
   p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_clr && !mask_set) |=> !mask);
   p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sense.edge_mode && pend && !wclr) |=> latch_q);
   p_wedge_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sense.edge_mode && wclr && !edge_hit) |=> !latch_q);
endmodule

// File: rtl/shint_route_table.sv
module shint_route_table #(
   parameter int NUM_SRC  = 64,
   parameter int NUM_CORE = 4,
   parameter int PIN_W    = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_core,
   input  logic                        wr_pin,
   input  logic [7:0]                  idx,
   input  logic [NUM_CORE-1:0]         core_val,
   input  logic                        pin_valid,
   input  logic [PIN_W-1:0]            pin_val,
   output logic [NUM_SRC*NUM_CORE-1:0] route_flat,
   output logic [NUM_SRC-1:0]          pin_ok,
   output logic [NUM_SRC*PIN_W-1:0]    pin_flat
);
   logic [NUM_CORE-1:0] pick;
   assign pick = core_val & (-core_val);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            route_flat[i*NUM_CORE +: NUM_CORE] <= NUM_CORE'(1);
            pin_ok[i]                          <= 1'b0;
            pin_flat[i*PIN_W +: PIN_W]         <= '0;
         end else begin
            if (wr_core && idx == 8'(i))
               route_flat[i*NUM_CORE +: NUM_CORE] <= pick;
            if (wr_pin && idx == 8'(i)) begin
               pin_ok[i]                  <= pin_valid;
               pin_flat[i*PIN_W +: PIN_W] <= pin_val;
            end
         end
      end
   end
endmodule

// File: rtl/shint_core_merge.sv
module shint_core_merge #(
   parameter int NUM_SRC  = 64,
   parameter int NUM_CORE = 4,
   parameter int PIN_W    = 3,
   localparam int NUM_PIN = 1 << PIN_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          active,
   input  logic [NUM_SRC*NUM_CORE-1:0] route_flat,
   input  logic [NUM_SRC-1:0]          pin_ok,
   input  logic [NUM_SRC*PIN_W-1:0]    pin_flat,
   output logic [NUM_CORE-1:0]         core_irq,
   output logic [NUM_CORE*NUM_PIN-1:0] core_pin_irq
);
   for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int i = 0; i < NUM_SRC; i++)
            hit = hit | (active[i] & route_flat[i*NUM_CORE+c]);
      end
      assign core_irq[c] = hit;

      for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
         logic phit;
         always_comb begin
            phit = 1'b0;
            for (int i = 0; i < NUM_SRC; i++)
               phit = phit | (active[i] & route_flat[i*NUM_CORE+c] & pin_ok[i]
                              & (pin_flat[i*PIN_W +: PIN_W] == PIN_W'(p)));
         end
         assign core_pin_irq[c*NUM_PIN+p] = phit;

         p_pin_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
            core_pin_irq[c*NUM_PIN+p] |-> core_irq[c]);
      end
   end
endmodule

// File: rtl/shared_irq_cond.sv
module shared_irq_cond
   import shint_pkg::*;
#(
   parameter int NUM_SRC  = 64,
   parameter int NUM_CORE = 4,
   parameter int PIN_W    = 3,
   parameter bit SYNC_EN  = 1'b1,
   localparam int NUM_PIN = 1 << PIN_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          src_in,
   input  logic                        bus_wr,
   input  logic [11:0]                 bus_addr,
   input  logic [31:0]                 bus_wdata,
   output logic [31:0]                 bus_rdata,
   output logic [NUM_CORE-1:0]         core_irq,
   output logic [NUM_CORE*NUM_PIN-1:0] core_pin_irq
);
   generate
      if (NUM_SRC % 8 != 0 || NUM_SRC < 8 || NUM_SRC > 256) begin : g_bad_src
         $error("NUM_SRC must be a multiple of 8 in 8..256");
      end
      if (NUM_CORE < 1 || NUM_CORE > 32) begin : g_bad_core
         $error("NUM_CORE must be in 1..32");
      end
      if (PIN_W < 1 || PIN_W > 5) begin : g_bad_pin
         $error("PIN_W must be in 1..5");
      end
   endgenerate

   localparam logic [31:0] CFG_WORD = {8'h00, 8'(NUM_SRC/8 - 1), 8'h00, 8'(NUM_CORE - 1)};

   logic [4:0] win, wk;
   logic [7:0] ridx;
   logic       aligned, is_pin, is_core, wedge_hit;
   assign win       = bus_addr[11:7];
   assign wk        = bus_addr[6:2];
   assign ridx      = bus_addr[9:2];
   assign aligned   = (bus_addr[1:0] == 2'b00);
   assign is_pin    = (bus_addr[11:10] == REG_PIN);
   assign is_core   = (bus_addr[11:10] == REG_CORE);
   assign wedge_hit = bus_wr && aligned && (bus_addr == A_WEDGE);

   logic [NUM_SRC-1:0] pol_q, trig_q, dual_q, pend_v, mask_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '0;
         trig_q <= '0;
         dual_q <= '0;
      end else if (bus_wr && aligned) begin
         for (int i = 0; i < NUM_SRC; i++) begin
            if (wk == 5'(i / 32)) begin
               if (win == WIN_POL)  pol_q[i]  <= bus_wdata[i % 32];
               if (win == WIN_TRIG) trig_q[i] <= bus_wdata[i % 32];
               if (win == WIN_DUAL) dual_q[i] <= bus_wdata[i % 32];
            end
         end
      end
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      sense_t sn;
      logic   hit_w, ms, mc, ws, wc;
      assign sn    = '{neg: pol_q[i], edge_mode: trig_q[i], both: dual_q[i]};
      assign hit_w = bus_wr && aligned && (wk == 5'(i / 32)) && bus_wdata[i % 32];
      assign ms    = hit_w && (win == WIN_SMASK);
      assign mc    = hit_w && (win == WIN_RMASK);
      assign ws    = wedge_hit && bus_wdata[CMD_BIT] && (bus_wdata[7:0] == 8'(i));
      assign wc    = wedge_hit && !bus_wdata[CMD_BIT] && (bus_wdata[7:0] == 8'(i));

      shint_src_cell #(.SYNC_EN(SYNC_EN)) u_cell (
         .clk(clk), .rst_n(rst_n), .src_in(src_in[i]), .sense(sn),
         .wset(ws), .wclr(wc), .mask_set(ms), .mask_clr(mc),
         .pend(pend_v[i]), .mask(mask_v[i])
      );
   end

   logic [NUM_SRC*NUM_CORE-1:0] route_flat;
   logic [NUM_SRC-1:0]          pin_ok;
   logic [NUM_SRC*PIN_W-1:0]    pin_flat;

   shint_route_table #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .PIN_W(PIN_W)) u_route (
      .clk(clk), .rst_n(rst_n),
      .wr_core(bus_wr && aligned && is_core),
      .wr_pin(bus_wr && aligned && is_pin),
      .idx(ridx), .core_val(bus_wdata[NUM_CORE-1:0]),
      .pin_valid(bus_wdata[VALID_BIT]), .pin_val(bus_wdata[PIN_W-1:0]),
      .route_flat(route_flat), .pin_ok(pin_ok), .pin_flat(pin_flat)
   );

   shint_core_merge #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .PIN_W(PIN_W)) u_merge (
      .clk(clk), .rst_n(rst_n), .active(pend_v & mask_v),
      .route_flat(route_flat), .pin_ok(pin_ok), .pin_flat(pin_flat),
      .core_irq(core_irq), .core_pin_irq(core_pin_irq)
   );

   function automatic logic [31:0] word_of(input logic [NUM_SRC-1:0] v, input logic [4:0] k);
      logic [31:0] w;
      w = '0;
      for (int b = 0; b < 32; b++) begin
         int idx;
         idx = int'(k) * 32 + b;
         if (idx < NUM_SRC) w[b] = v[idx];
      end
      return w;
   endfunction

   always_comb begin
      bus_rdata = '0;
      if (is_pin) begin
         for (int i = 0; i < NUM_SRC; i++)
            if (ridx == 8'(i)) begin
               bus_rdata            = 32'(pin_flat[i*PIN_W +: PIN_W]);
               bus_rdata[VALID_BIT] = pin_ok[i];
            end
      end else if (is_core) begin
         for (int i = 0; i < NUM_SRC; i++)
            if (ridx == 8'(i)) bus_rdata = 32'(route_flat[i*NUM_CORE +: NUM_CORE]);
      end else begin
         case (win)
            5'd0:     if (bus_addr == A_CFG) bus_rdata = CFG_WORD;
            WIN_POL:  bus_rdata = word_of(pol_q, wk);
            WIN_TRIG: bus_rdata = word_of(trig_q, wk);
            WIN_DUAL: bus_rdata = word_of(dual_q, wk);
            WIN_PEND: bus_rdata = word_of(pend_v, wk);
            WIN_MASK: bus_rdata = word_of(mask_v, wk);
            default:  bus_rdata = '0;
         endcase
      end
   end

   p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|core_irq) |-> (|(pend_v & mask_v)));
endmodule

// File: tb/shared_irq_cond_bench.sv
module shared_irq_cond_bench;
   localparam int NS = 64;
   localparam int NC = 4;
   localparam int PW = 3;
   localparam int NP = 1 << PW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NS-1:0]     src_in = '0;
   logic              bus_wr = 1'b0;
   logic [11:0]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NC-1:0]     core_irq;
   logic [NC*NP-1:0]  core_pin_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   shared_irq_cond #(.NUM_SRC(NS), .NUM_CORE(NC), .PIN_W(PW)) u_shared_irq_cond (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_irq(core_irq), .core_pin_irq(core_pin_irq)
   );

   // behavioural reference model
   bit m_s1[NS], m_s2[NS], m_pv[NS], m_mask[NS], m_pol[NS], m_trig[NS];
   bit m_dual[NS], m_sw[NS], m_lat[NS], m_pok[NS];
   int m_route[NS], m_pin[NS];

   function automatic bit m_pend(int i);
      return m_trig[i] ? m_lat[i] : ((m_s2[i] ^ m_pol[i]) | m_sw[i]);
   endfunction

   function automatic logic [NC-1:0] exp_irq();
      logic [NC-1:0] r = '0;
      for (int i = 0; i < NS; i++)
         if (m_pend(i) && m_mask[i] && m_route[i] >= 0) r[m_route[i]] = 1'b1;
      return r;
   endfunction

   function automatic logic [NC*NP-1:0] exp_pins();
      logic [NC*NP-1:0] r = '0;
      for (int i = 0; i < NS; i++)
         if (m_pend(i) && m_mask[i] && m_route[i] >= 0 && m_pok[i])
            r[m_route[i]*NP + m_pin[i]] = 1'b1;
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin
            m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; m_mask[i] = 0; m_pol[i] = 0;
            m_trig[i] = 0; m_dual[i] = 0; m_sw[i] = 0; m_lat[i] = 0; m_pok[i] = 0;
            m_route[i] = 0; m_pin[i] = 0;
         end
      end else begin
         bit wedge;
         wedge = bus_wr && bus_addr == 12'h004;
         for (int i = 0; i < NS; i++) begin
            bit e, ws, wc;
            ws = wedge && bus_wdata[31] && bus_wdata[7:0] == i;
            wc = wedge && !bus_wdata[31] && bus_wdata[7:0] == i;
            if (m_dual[i])     e = m_s2[i] != m_pv[i];
            else if (m_pol[i]) e = m_pv[i] && !m_s2[i];
            else               e = !m_pv[i] && m_s2[i];
            if (!m_trig[i]) m_lat[i] = 0;
            else m_lat[i] = (m_lat[i] && !wc) || e || ws;
            if (ws) m_sw[i] = 1; else if (wc) m_sw[i] = 0;
            m_pv[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = src_in[i];
         end
         if (bus_wr && bus_addr[1:0] == 2'b00) begin
            int a;
            a = int'(bus_addr);
            if (a >= 'h100 && a < 'h480) begin
               int win, k;
               win = a >> 7; k = (a >> 2) & 31;
               for (int b = 0; b < 32; b++) begin
                  int i;
                  i = k * 32 + b;
                  if (i < NS) begin
                     if (win == 2) m_pol[i]  = bus_wdata[b];
                     if (win == 3) m_trig[i] = bus_wdata[b];
                     if (win == 4) m_dual[i] = bus_wdata[b];
                     if (win == 7 && bus_wdata[b]) m_mask[i] = 1;
                     if (win == 8 && bus_wdata[b]) m_mask[i] = 0;
                  end
               end
            end else if (a >= 'h800 && a < 'hC00) begin
               int i;
               i = (a - 'h800) >> 2;
               if (i < NS) begin m_pok[i] = bus_wdata[31]; m_pin[i] = int'(bus_wdata[PW-1:0]); end
            end else if (a >= 'hC00) begin
               int i;
               i = (a - 'hC00) >> 2;
               if (i < NS) begin
                  m_route[i] = -1;
                  for (int c = NC - 1; c >= 0; c--) if (bus_wdata[c]) m_route[i] = c;
               end
            end
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (core_irq !== exp_irq()) begin
            n_fail++;
            $display("FAIL R7 core_irq got %h exp %h at %0t", core_irq, exp_irq(), $time);
         end
         n_chk++;
         if (core_pin_irq !== exp_pins()) begin
            n_fail++;
            $display("FAIL R8 core_pin_irq got %h exp %h at %0t", core_pin_irq, exp_pins(), $time);
         end
      end
   end

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      #1;
      chk(bus_rdata, exp, tag);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL R1 watchdog got running exp finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      idle(1);
      // R10 config, R1 reset state
      rd(12'h000, 32'h0007_0003, "R10 config");
      rd(12'h300, 32'h0, "R1 mask reset");
      rd(12'h280, 32'h0, "R1 pending reset");
      rd(12'h180, 32'h0, "R1 trigger reset");
      rd(12'h100, 32'h0, "R1 polarity reset");
      rd(12'hC00, 32'h1, "R1 core map reset");
      rd(12'h800, 32'h0, "R1 pin map reset");
      chk(32'(core_irq), 32'h0, "R1 core_irq reset");
      // R2 mask set/clear
      wr(12'h380, 32'h0000_00FF);
      wr(12'h400, 32'h0000_0008);
      rd(12'h300, 32'h0000_00F7, "R2 set then clear");
      wr(12'h400, 32'h0);
      rd(12'h300, 32'h0000_00F7, "R2 zero bits no effect");
      wr(12'h384, 32'h8000_0000);
      rd(12'h304, 32'h8000_0000, "R9 second mask word");
      // R3 level, R7 routing
      src_in[1] = 1'b1;
      idle(3);
      rd(12'h280, 32'h2, "R3 level high");
      chk(32'(core_irq), 32'h1, "R7 default core 0");
      wr(12'hC04, 32'h0000_000C);
      chk(32'(core_irq), 32'h4, "R7 lowest bit picks core 2");
      rd(12'hC04, 32'h4, "R7 route readback");
      src_in[1] = 1'b0;
      idle(3);
      rd(12'h280, 32'h0, "R3 level not latched");
      wr(12'h100, 32'h4);
      rd(12'h280, 32'h4, "R3 active low");
      chk(32'(core_irq), 32'h1, "R3 active low reaches core");
      wr(12'h100, 32'h0);
      // R4 rising edge
      wr(12'h180, 32'h10);
      src_in[4] = 1'b1;
      idle(1);
      src_in[4] = 1'b0;
      idle(5);
      rd(12'h280, 32'h10, "R4 rising pulse latched");
      wr(12'h004, 32'h4);
      rd(12'h280, 32'h0, "R6 clear acknowledges edge");
      // R4 falling edge
      wr(12'h100, 32'h20);
      wr(12'h180, 32'h30);
      src_in[5] = 1'b1;
      idle(5);
      rd(12'h280, 32'h0, "R4 rise ignored when active low");
      src_in[5] = 1'b0;
      idle(5);
      rd(12'h280, 32'h20, "R4 falling edge latched");
      wr(12'h004, 32'h5);
      rd(12'h280, 32'h0, "R6 ack falling");
      // R5 both edges, polarity ignored
      wr(12'h100, 32'h60);
      wr(12'h200, 32'h40);
      wr(12'h180, 32'h70);
      src_in[6] = 1'b1;
      idle(5);
      rd(12'h280, 32'h40, "R5 rise latched");
      wr(12'h004, 32'h6);
      rd(12'h280, 32'h0, "R5 ack");
      src_in[6] = 1'b0;
      idle(5);
      rd(12'h280, 32'h40, "R5 fall latched");
      wr(12'h004, 32'h6);
      // R6 wedge on level source 40
      wr(12'h004, 32'h8000_0028);
      rd(12'h284, 32'h100, "R6 wedge set level");
      wr(12'h384, 32'h100);
      wr(12'hCA0, 32'h8);
      chk(32'(core_irq), 32'h8, "R7 source 40 to core 3");
      wr(12'h004, 32'h28);
      rd(12'h284, 32'h0, "R6 wedge clear level");
      chk(32'(core_irq), 32'h0, "R7 no active source");
      wr(12'h004, 32'h8000_0004);
      rd(12'h280, 32'h10, "R6 wedge set edge");
      wr(12'h004, 32'h4);
      rd(12'h280, 32'h0, "R6 wedge clear edge");
      // R8 pin map
      wr(12'h804, 32'h8000_0005);
      rd(12'h804, 32'h8000_0005, "R8 pin readback");
      src_in[1] = 1'b1;
      idle(3);
      chk(32'(core_pin_irq), 32'h0020_0000, "R8 core 2 pin 5");
      wr(12'hC04, 32'h3);
      rd(12'hC04, 32'h1, "R7 reroute clears old core");
      chk(32'(core_pin_irq), 32'h20, "R8 core 0 pin 5");
      chk(32'(core_irq), 32'h1, "R7 moved to core 0");
      wr(12'h004, 32'h8000_0050);
      rd(12'h284, 32'h0, "R6 out of range index");
      rd(12'h280, 32'h2, "R6 out of range no effect");
      wr(12'h804, 32'h5);
      chk(32'(core_pin_irq), 32'h0, "R8 invalid map");
      wr(12'h400, 32'h2);
      chk(32'(core_irq), 32'h0, "R2 masked source silent");
      rd(12'h280, 32'h2, "R9 pending shown while masked");
      idle(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule